// File: doc/BRIEF.md
# Multi-Level Vectored Interrupt Controller

This block collects up to 63 interrupt request lines, sorts the unmasked ones into seven interrupt levels with a finer priority order inside each level, and presents the highest active level to the processor. Sources 1 to 7 are hard-wired: source n always belongs to level n and sits at a fixed middle slot of that level. Sources 8 to 63 are programmable. Each has a control register that holds its level and its priority within that level. A 64-bit mask register holds one mask bit per source. Bit 0 of the mask is a mask-all control.

Software reads the winning vector through a simple synchronous register port. A per-level acknowledge read returns the best request at one level. A software acknowledge read returns the best request anywhere in this controller. A global per-level acknowledge read also weighs a candidate arriving on the cascade inputs. The merged candidate for each level leaves on the cascade outputs, so several instances can be chained and the last one answers for all of them. A vector is 64 plus the source number. A read that finds nothing pending returns the spurious vector 24.

Top module: `intc_top`

## Requirements
- R1: After a synchronous reset, `ipl_o` and `rdata_o` are 0, every programmable control register reads 0, and both mask words (addresses 64 and 65) read 32'hFFFFFFFF.
- R2: Fixed source n (1..7) is always at level n. Its rank lies between the programmable priorities: it beats priority 3 and loses to priority 4 at the same level.
- R3: The control register of source s (8..63) is at address s. Bits [2:0] hold the priority (7 highest) and bits [5:3] hold the level. Level 0 disables the source.
- R4: A read at address 72+L (L = 1..7) returns, one cycle later, 64 plus the number of the winning unmasked pending source at level L.
- R5: An acknowledge read that finds no eligible request returns 24.
- R6: A read at address 80 returns the vector of the winner at the highest level that has an eligible request.
- R7: `ipl_o` equals the highest level that has an eligible request, or 0 when there is none. It is updated at the first clock edge after the inputs change.
- R8: Mask bit s (bit s mod 32 of word 64 + s/32) set to 1 excludes source s from every arbitration.
- R9: Mask bit 0 set to 1 excludes all sources, whatever the other mask bits hold.
- R10: When two eligible sources share a level and a priority, the lower source number wins.
- R11: A read at address 88+L returns the better of the local level-L winner and the cascade candidate for level L: the higher rank wins, and on equal rank the lower vector wins. The cascade output carries that merged candidate in the same cycle. Ranks are 0..3 for priorities 0..3, 4 for a fixed source, and 5..8 for priorities 4..7.
- R12: Writes to addresses 1..7 have no effect: those addresses read 0 and the fixed levels stay the same. Request line 0 never raises a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 64 | Request lines, bit s for source s (bit 0 unused) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 7 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the read strobe, otherwise 0 |
| ipl_o | output | 3 | Highest active interrupt level to the processor |
| casc_vld_i | input | 7 | Cascade candidate valid per level (bit L-1 for level L) |
| casc_rank_i | input | 28 | Cascade candidate rank per level, 4 bits each |
| casc_vec_i | input | 56 | Cascade candidate vector per level, 8 bits each |
| casc_vld_o | output | 7 | Merged candidate valid per level |
| casc_rank_o | output | 28 | Merged candidate rank per level |
| casc_vec_o | output | 56 | Merged candidate vector per level |

## Verification
The interrupt level reflects the request and mask state seen at a rising edge, and it becomes visible right after that edge. Read data appears one edge after the read strobe. The data is computed from the configuration as it stood before any write at that same edge. The cascade outputs are combinational and follow their inputs within the same cycle. The bench drives all inputs on falling edges. At each rising edge its behavioural model works out the level and read data due from the inputs, then applies any write. It compares those values, and the cascade outputs for the current inputs, at the following falling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int NUM_SRC    = 64;
  localparam int NUM_LVL    = 7;
  localparam int NUM_PRI    = 8;
  localparam int LVL_W      = $clog2(NUM_LVL + 1);
  localparam int PRI_W      = $clog2(NUM_PRI);
  localparam int RANK_W     = $clog2(NUM_PRI + 2);
  localparam int VEC_W      = 8;
  localparam int FIRST_PROG = NUM_LVL + 1;
  localparam int VEC_BASE   = 64;
  localparam int VEC_SPUR   = 24;
  localparam int MID_RANK   = NUM_PRI / 2;

  typedef struct packed {
    logic              vld;
    logic [RANK_W-1:0] rank;
    logic [VEC_W-1:0]  vec;
  } cand_t;

  // Priorities at or above the midpoint move up one rank, which leaves the
  // midpoint rank free for the fixed source of the level.
  function automatic logic [RANK_W-1:0] prog_rank(logic [PRI_W-1:0] p);
    if (int'(p) >= MID_RANK) return RANK_W'(int'(p) + 1);
    return RANK_W'(p);
  endfunction

  // Returns 1 when a strictly beats b: higher rank, and on equal rank the lower vector.
  function automatic logic beats(cand_t a, cand_t b);
    if (!a.vld) return 1'b0;
    if (!b.vld) return 1'b1;
    if (a.rank != b.rank) return a.rank > b.rank;
    return a.vec < b.vec;
  endfunction

endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int MASK_BASE = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [NUM_SRC*LVL_W-1:0] lvl_o,
  output logic [NUM_SRC*PRI_W-1:0] pri_o,
  output logic [NUM_SRC-1:0]       mask_o,
  output logic [DATA_W-1:0]        cfg_rdata_o
);

  localparam int MASK_WORDS = NUM_SRC / DATA_W;

  logic [NUM_SRC-1:0] mask_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s >= FIRST_PROG) begin : g_prog
      logic [LVL_W-1:0] lvl_q;
      logic [PRI_W-1:0] pri_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lvl_q <= '0;
          pri_q <= '0;
        end else if (wr_en_i && int'(addr_i) == s) begin
          lvl_q <= wdata_i[PRI_W +: LVL_W];
          pri_q <= wdata_i[0 +: PRI_W];
        end
      end
      assign lvl_o[s*LVL_W +: LVL_W] = lvl_q;
      assign pri_o[s*PRI_W +: PRI_W] = pri_q;
    end else begin : g_fixed
      // Fixed sources: source n lives at level n; source 0 gets level 0 and never wins.
      assign lvl_o[s*LVL_W +: LVL_W] = LVL_W'(s);
      assign pri_o[s*PRI_W +: PRI_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en_i) begin
      for (int w = 0; w < MASK_WORDS; w++) begin
        if (int'(addr_i) == MASK_BASE + w) mask_q[w*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end

  assign mask_o = mask_q;

  always_comb begin
    int a;
    a = int'(addr_i);
    cfg_rdata_o = '0;
    if (a >= FIRST_PROG && a < NUM_SRC) begin
      cfg_rdata_o[PRI_W +: LVL_W] = lvl_o[a*LVL_W +: LVL_W];
      cfg_rdata_o[0 +: PRI_W]     = pri_o[a*PRI_W +: PRI_W];
    end
    for (int w = 0; w < MASK_WORDS; w++) begin
      if (a == MASK_BASE + w) cfg_rdata_o = mask_q[w*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb
  import intc_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC-1:0]       mask_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  input  logic [NUM_SRC*PRI_W-1:0] pri_i,
  output cand_t                    best_o
);

  always_comb begin
    cand_t best;
    cand_t c;
    best = '0;
    // Ascending scan with a strict comparison: on a full tie the lower source is kept.
    for (int s = 0; s < NUM_SRC; s++) begin
      c.vld  = req_i[s] & ~mask_i[s] & ~mask_i[0] &
               (lvl_i[s*LVL_W +: LVL_W] == LVL_W'(LEVEL));
      c.rank = (s < FIRST_PROG) ? RANK_W'(MID_RANK) : prog_rank(pri_i[s*PRI_W +: PRI_W]);
      c.vec  = VEC_W'(VEC_BASE + s);
      if (beats(c, best)) best = c;
    end
    best_o = best;
  end

endmodule

// File: rtl/intc_cand_merge.sv
module intc_cand_merge
  import intc_pkg::*;
(
  input  cand_t local_i,
  input  cand_t casc_i,
  output cand_t merged_o
);

  always_comb begin
    if (!local_i.vld && !casc_i.vld) merged_o = '0;
    else if (beats(casc_i, local_i))  merged_o = casc_i;
    else                              merged_o = local_i;
  end

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int MASK_BASE  = 64,
  parameter int LACK_BASE  = 72,
  parameter int SWACK_ADDR = 80,
  parameter int GACK_BASE  = 88
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [LVL_W-1:0]          ipl_o,
  input  logic [NUM_LVL-1:0]        casc_vld_i,
  input  logic [NUM_LVL*RANK_W-1:0] casc_rank_i,
  input  logic [NUM_LVL*VEC_W-1:0]  casc_vec_i,
  output logic [NUM_LVL-1:0]        casc_vld_o,
  output logic [NUM_LVL*RANK_W-1:0] casc_rank_o,
  output logic [NUM_LVL*VEC_W-1:0]  casc_vec_o
);

  logic [NUM_SRC*LVL_W-1:0] lvl_w;
  logic [NUM_SRC*PRI_W-1:0] pri_w;
  logic [NUM_SRC-1:0]       mask_w;
  logic [DATA_W-1:0]        cfg_rdata;
  logic                     mask_all_w;

  cand_t loc_best  [0:NUM_LVL];
  cand_t glob_best [0:NUM_LVL];
  cand_t sw_best;
  logic [LVL_W-1:0]  ipl_next;
  logic [DATA_W-1:0] rd_next;

  intc_cfg_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MASK_BASE(MASK_BASE)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .lvl_o      (lvl_w),
    .pri_o      (pri_w),
    .mask_o     (mask_w),
    .cfg_rdata_o(cfg_rdata)
  );

  assign mask_all_w   = mask_w[0];
  assign loc_best[0]  = '0;
  assign glob_best[0] = '0;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    cand_t casc_in;

    intc_level_arb #(.LEVEL(l)) u_arb (
      .req_i (req_i),
      .mask_i(mask_w),
      .lvl_i (lvl_w),
      .pri_i (pri_w),
      .best_o(loc_best[l])
    );

    assign casc_in.vld  = casc_vld_i[l-1];
    assign casc_in.rank = casc_rank_i[(l-1)*RANK_W +: RANK_W];
    assign casc_in.vec  = casc_vec_i[(l-1)*VEC_W +: VEC_W];

    intc_cand_merge u_merge (
      .local_i (loc_best[l]),
      .casc_i  (casc_in),
      .merged_o(glob_best[l])
    );

    assign casc_vld_o[l-1]                   = glob_best[l].vld;
    assign casc_rank_o[(l-1)*RANK_W +: RANK_W] = glob_best[l].rank;
    assign casc_vec_o[(l-1)*VEC_W +: VEC_W]    = glob_best[l].vec;
  end

  function automatic logic [DATA_W-1:0] vec_word(cand_t c);
    return c.vld ? DATA_W'(c.vec) : DATA_W'(VEC_SPUR);
  endfunction

  // The highest level that has a local winner drives both the core level and the software acknowledge.
  always_comb begin
    sw_best  = '0;
    ipl_next = '0;
    for (int l = 1; l <= NUM_LVL; l++) begin
      if (loc_best[l].vld) begin
        sw_best  = loc_best[l];
        ipl_next = LVL_W'(l);
      end
    end
  end

  always_comb begin
    int a;
    a = int'(addr_i);
    rd_next = cfg_rdata;
    if (a > LACK_BASE && a <= LACK_BASE + NUM_LVL)
      rd_next = vec_word(loc_best[a - LACK_BASE]);
    else if (a == SWACK_ADDR)
      rd_next = vec_word(sw_best);
    else if (a > GACK_BASE && a <= GACK_BASE + NUM_LVL)
      rd_next = vec_word(glob_best[a - GACK_BASE]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl_o   <= '0;
      rdata_o <= '0;
    end else begin
      ipl_o   <= ipl_next;
      rdata_o <= rd_en_i ? rd_next : '0;
    end
  end

endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int LACK_BASE  = 72,
  parameter int SWACK_ADDR = 80
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [LVL_W-1:0]   ipl_o,
  input logic               mask_all,
  input logic [NUM_LVL-1:0] casc_vld_i,
  input logic [NUM_LVL-1:0] casc_vld_o
);

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i[NUM_SRC-1:1] == '0) |=> (ipl_o == '0));

  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (rst)
    mask_all |=> (ipl_o == '0));

  // R5
  spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && int'(addr_i) == SWACK_ADDR && req_i[NUM_SRC-1:1] == '0)
    |=> (rdata_o == DATA_W'(VEC_SPUR)));

  // R4
  level_vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && int'(addr_i) > LACK_BASE && int'(addr_i) <= LACK_BASE + NUM_LVL)
    |=> (rdata_o == DATA_W'(VEC_SPUR) ||
         (rdata_o > DATA_W'(VEC_BASE) && rdata_o < DATA_W'(VEC_BASE + NUM_SRC))));

  // R11
  casc_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ((casc_vld_i & ~casc_vld_o) == '0));

endmodule

bind intc_top intc_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LACK_BASE (LACK_BASE),
  .SWACK_ADDR(SWACK_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .ipl_o     (ipl_o),
  .mask_all  (mask_all_w),
  .casc_vld_i(casc_vld_i),
  .casc_vld_o(casc_vld_o)
);

// File: tb/intc_top_test.sv
module intc_top_test;
  import intc_pkg::*;

  localparam int ADDR_W = 7, DATA_W = 32;
  localparam int MASK_BASE = 64, LACK = 72, SWACK = 80, GACK = 88;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NUM_SRC-1:0]        req = '0;
  logic                      wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0]         addr = '0;
  logic [DATA_W-1:0]         wdata = '0;
  logic [DATA_W-1:0]         rdata;
  logic [LVL_W-1:0]          ipl;
  logic [NUM_LVL-1:0]        cvld_i = '0;
  logic [NUM_LVL*RANK_W-1:0] crank_i = '0;
  logic [NUM_LVL*VEC_W-1:0]  cvec_i = '0;
  logic [NUM_LVL-1:0]        cvld_o;
  logic [NUM_LVL*RANK_W-1:0] crank_o;
  logic [NUM_LVL*VEC_W-1:0]  cvec_o;

  intc_top uut (
    .clk(clk), .rst(rst), .req_i(req), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ipl_o(ipl),
    .casc_vld_i(cvld_i), .casc_rank_i(crank_i), .casc_vec_i(cvec_i),
    .casc_vld_o(cvld_o), .casc_rank_o(crank_o), .casc_vec_o(cvec_o)
  );

  int errors = 0, checks = 0;
  bit run_cmp = 1'b0;

  int lvl_m [NUM_SRC];
  int pri_m [NUM_SRC];
  logic [NUM_SRC-1:0] mask_m = '1;
  int exp_ipl = 0;
  logic [DATA_W-1:0] exp_rdata = '0;

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_lvl(int s);
    return (s < FIRST_PROG) ? s : lvl_m[s];
  endfunction

  function automatic int m_rank(int s);
    if (s < FIRST_PROG) return MID_RANK;
    return (pri_m[s] >= MID_RANK) ? pri_m[s] + 1 : pri_m[s];
  endfunction

  // Local winner at a level as a source number, 0 when none.
  function automatic int m_best(int lv);
    int best = 0;
    for (int s = 1; s < NUM_SRC; s++) begin
      if (req[s] && !mask_m[s] && !mask_m[0] && m_lvl(s) == lv)
        if (best == 0 || m_rank(s) > m_rank(best)) best = s;
    end
    return best;
  endfunction

  function automatic int m_vec(int s);
    return (s == 0) ? VEC_SPUR : VEC_BASE + s;
  endfunction

  // Merged candidate at a level: returns the vector, 0 when none.
  function automatic int m_glob(int lv, output int rank);
    int s, cr, cv;
    s = m_best(lv);
    cr = int'(crank_i[(lv-1)*RANK_W +: RANK_W]);
    cv = int'(cvec_i[(lv-1)*VEC_W +: VEC_W]);
    if (!cvld_i[lv-1]) begin
      rank = (s == 0) ? 0 : m_rank(s);
      return (s == 0) ? 0 : VEC_BASE + s;
    end
    if (s == 0 || cr > m_rank(s) || (cr == m_rank(s) && cv < VEC_BASE + s)) begin
      rank = cr;
      return cv;
    end
    rank = m_rank(s);
    return VEC_BASE + s;
  endfunction

  function automatic int m_ipl();
    int r = 0;
    for (int l = 1; l <= NUM_LVL; l++) if (m_best(l) != 0) r = l;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] m_read(int a);
    int rk, v;
    if (a >= FIRST_PROG && a < NUM_SRC) return DATA_W'(lvl_m[a] * NUM_PRI + pri_m[a]);
    if (a == MASK_BASE)     return mask_m[31:0];
    if (a == MASK_BASE + 1) return mask_m[63:32];
    if (a > LACK && a <= LACK + NUM_LVL) return DATA_W'(m_vec(m_best(a - LACK)));
    if (a == SWACK) return DATA_W'(m_vec(m_best(m_ipl())));
    if (a > GACK && a <= GACK + NUM_LVL) begin
      v = m_glob(a - GACK, rk);
      return DATA_W'((v == 0) ? VEC_SPUR : v);
    end
    return '0;
  endfunction

  // Reference model: values due after this edge, then the write of this edge.
  always @(posedge clk) begin
    if (rst) begin
      exp_ipl = 0;
      exp_rdata = '0;
      mask_m = '1;
      for (int s = 0; s < NUM_SRC; s++) begin
        lvl_m[s] = 0;
        pri_m[s] = 0;
      end
    end else begin
      exp_ipl = m_ipl();
      exp_rdata = rd_en ? m_read(int'(addr)) : '0;
      if (wr_en) begin
        if (int'(addr) >= FIRST_PROG && int'(addr) < NUM_SRC) begin
          lvl_m[int'(addr)] = int'(wdata[5:3]);
          pri_m[int'(addr)] = int'(wdata[2:0]);
        end
        if (int'(addr) == MASK_BASE)     mask_m[31:0]  = wdata;
        if (int'(addr) == MASK_BASE + 1) mask_m[63:32] = wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R7 ipl_o", DATA_W'(ipl), DATA_W'(exp_ipl));
      chk("R4 rdata_o", rdata, exp_rdata);
      for (int l = 1; l <= NUM_LVL; l++) begin
        int rk, v;
        v = m_glob(l, rk);
        chk("R11 casc_vld_o", DATA_W'(cvld_o[l-1]), DATA_W'(v != 0));
        if (v != 0) begin
          chk("R11 casc_vec_o", DATA_W'(cvec_o[(l-1)*VEC_W +: VEC_W]), DATA_W'(v));
          chk("R11 casc_rank_o", DATA_W'(crank_o[(l-1)*RANK_W +: RANK_W]), DATA_W'(rk));
        end
      end
    end
  end

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, DATA_W'(exp));
  endtask

  task automatic set_req(logic [NUM_SRC-1:0] v);
    @(negedge clk);
    req = v;
  endtask

  task automatic chk_ipl(int exp, string tag);
    @(negedge clk);
    chk(tag, DATA_W'(ipl), DATA_W'(exp));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [NUM_SRC-1:0] bit_of(int s);
    return NUM_SRC'(1) << s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_cmp = 1'b1;
    // R1 reset state
    chk("R1 ipl after reset", DATA_W'(ipl), '0);
    chk("R1 rdata after reset", rdata, '0);
    rd(MASK_BASE, 32'hFFFFFFFF, "R1 mask lo");
    rd(MASK_BASE + 1, 32'hFFFFFFFF, "R1 mask hi");
    rd(8, 0, "R1 ctrl reg");
    wr(MASK_BASE, '0);
    wr(MASK_BASE + 1, '0);
    // R2 fixed source at its own level
    set_req(bit_of(3));
    chk_ipl(3, "R2 fixed level");
    rd(LACK + 3, 67, "R2 fixed vector");
    rd(SWACK, 67, "R6 swack fixed");
    wr(10, (3 << 3) | 3);
    wr(11, (3 << 3) | 4);
    rd(11, (3 << 3) | 4, "R3 ctrl readback");
    set_req(bit_of(3) | bit_of(10));
    rd(LACK + 3, 67, "R2 beats prio 3");
    set_req(bit_of(3) | bit_of(10) | bit_of(11));
    rd(LACK + 3, 75, "R2 loses to prio 4");
    // R5 spurious
    rd(LACK + 5, VEC_SPUR, "R5 level spurious");
    rd(GACK + 5, VEC_SPUR, "R5 global spurious");
    // R6 highest level wins software acknowledge
    wr(40, (6 << 3) | 0);
    set_req(bit_of(3) | bit_of(10) | bit_of(11) | bit_of(40));
    chk_ipl(6, "R7 level 6");
    rd(SWACK, 104, "R6 swack level 6");
    rd(LACK + 6, 104, "R4 level 6 ack");
    // R8 individual mask (source 40 = word 65 bit 8)
    wr(MASK_BASE + 1, 32'h100);
    chk_ipl(3, "R8 masked src");
    rd(SWACK, 75, "R8 swack after mask");
    // R9 mask all
    wr(MASK_BASE, 32'h1);
    chk_ipl(0, "R9 mask all ipl");
    rd(SWACK, VEC_SPUR, "R9 mask all swack");
    wr(MASK_BASE, '0);
    wr(MASK_BASE + 1, '0);
    // R10 tie
    wr(20, (2 << 3) | 5);
    wr(21, (2 << 3) | 5);
    set_req(bit_of(20) | bit_of(21));
    rd(LACK + 2, 84, "R10 tie lower src");
    chk_ipl(2, "R10 level");
    // R3 level 0 disables
    wr(20, 5);
    rd(LACK + 2, 85, "R3 src 20 disabled");
    wr(21, 0);
    rd(LACK + 2, VEC_SPUR, "R3 both disabled");
    chk_ipl(0, "R3 no level");
    // R11 cascade
    wr(20, (2 << 3) | 6);
    @(negedge clk);
    cvld_i = 7'b0000010;
    crank_i[RANK_W +: RANK_W] = 4'd7;
    cvec_i[VEC_W +: VEC_W] = 8'd99;
    rd(GACK + 2, 84, "R11 tie lower vec");
    @(negedge clk);
    crank_i[RANK_W +: RANK_W] = 4'd8;
    rd(GACK + 2, 99, "R11 cascade higher rank");
    rd(LACK + 2, 84, "R11 local ack unaffected");
    @(negedge clk);
    crank_i[RANK_W +: RANK_W] = 4'd7;
    cvec_i[VEC_W +: VEC_W] = 8'd50;
    rd(GACK + 2, 50, "R11 cascade lower vec");
    chk("R11 casc_vld_o", DATA_W'(cvld_o), DATA_W'(7'b0000010));
    @(negedge clk);
    cvld_i = '0;
    // R12 fixed addresses ignore writes, request 0 ignored
    wr(5, 32'h3F);
    rd(5, 0, "R12 fixed addr reads 0");
    set_req(bit_of(5));
    chk_ipl(5, "R12 fixed level kept");
    rd(LACK + 5, 69, "R12 fixed vector kept");
    set_req(bit_of(0));
    chk_ipl(0, "R12 req 0 ignored");
    rd(SWACK, VEC_SPUR, "R12 req 0 swack");
    set_req('0);
    chk_ipl(0, "R7 idle");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule